// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block produces two pulse-width modulated outputs from a single module clock. The two channels share one control word and each has its own period/duty word. A channel first divides the module clock by a ratio picked from a coded, non-linear table. The divided ticks then step a 16-bit counter. The counter position sets whether the output is at its active or inactive level. The period field holds the period length minus one. The duty field holds the number of ticks spent at the active level.

Software writes new timing into a shadow register. The shadow is copied into the running counter only at a period boundary, so no period is ever cut short. A per-channel ready flag in the control word shows that such an update is still waiting. Three per-channel options change the normal behaviour. A bypass bit sends the raw module clock to the pin and overrides every other setting. A one-shot mode emits a single period on request. A lock stops the division code from changing while the channel clock is gated on.

Top module: `pwm_ctl`

## Requirements
- R1: After reset the control word and both period/duty words read as zero. Both outputs sit at the inactive level, which is high because the active-level bit is 0.
- R2: The control word is at address 0x0. Within the control word, channel n's fields start at bit 15·n: code [3:0], enable 4, active-level 5, clock gate 6, one-shot mode 7, pulse start 8, bypass 9. Channel n's period/duty word is at address 0x4+4·n, with the period minus one in [31:16] and the duty in [15:0]. A running channel with period field P and duty D<=P+1 spends D of every P+1 ticks at the active level.
- R3: With active-level 1 the output is high during the duty portion. With active-level 0 the waveform is inverted.
- R4: A duty of 0 keeps the output at the inactive level. A duty of P+1 or more keeps it at the active level for the whole period.
- R5: The code sets the clock cycles per tick: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1.
- R6: Codes 5–7 and 13–14 produce no output activity. The output stays at the inactive level.
- R7: A channel produces a waveform only when its enable and clock-gate bits are both 1. Otherwise it holds the inactive level.
- R8: With the bypass bit set, the output equals the module clock whatever the enable, gate, code and polarity bits are.
- R9: A write to a period/duty word sets ready bit 28+n of the control word. The new value takes effect, and the bit clears, at the next period boundary. If the channel is not running, this happens on the following clock.
- R10: A code written while the stored clock-gate bit is 1 is ignored. A code written while the gate is 0 is taken.
- R11: In one-shot mode, writing 1 to the pulse bit emits exactly one period and then returns to the inactive level. The pulse bit reads back as 0 once the period is over.
- R12: The channels are independent. Channel 1 is programmed through its own fields and address and drives only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; also the bypass output source |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | NCH | Per-channel waveform outputs |

## Verification
The hardest situation to reach is a period/duty update that arrives while a long period is running. The ready flag must stay set, and the old timing must stay in force, until the boundary. The bench reaches it by running a 100-tick period, writing new timing mid-period, and reading the flag one cycle later. It reads the flag again after the boundary, then measures the new duty over a whole number of periods. The long divider codes need windows of tens of thousands of cycles, so only a few representative codes are measured directly.

// File: rtl/pwm_ctl.sv
module pwm_ctl #(
  parameter int NCH   = 2,
  parameter int DIV_W = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CNT_W  = 16;
  localparam int STRIDE = 15;
  localparam int RDY_LO = 28;

  logic [NCH-1:0][3:0]       code;
  logic [NCH-1:0]            en, act, gate, mode, byp, busy, pend;
  logic [NCH-1:0]            run, tick, valid, wrap, xfer, q;
  logic [NCH-1:0][31:0]      shd, cur;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [NCH-1:0][DIV_W-1:0] pre, ratio;

  wire ctrl_we = reg_we && reg_addr == 4'h0;
  wire unused_wbits = ^{reg_wdata[14:10], reg_wdata[31:25]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int B = g * STRIDE;
    wire pd_we = reg_we && reg_addr == 4'(4 + 4 * g);
    wire start = ctrl_we && reg_wdata[B+7] && reg_wdata[B+8];

    always_comb begin
      case (code[g])
        4'd0:    ratio[g] = DIV_W'(120);
        4'd1:    ratio[g] = DIV_W'(180);
        4'd2:    ratio[g] = DIV_W'(240);
        4'd3:    ratio[g] = DIV_W'(360);
        4'd4:    ratio[g] = DIV_W'(480);
        4'd8:    ratio[g] = DIV_W'(12000);
        4'd9:    ratio[g] = DIV_W'(24000);
        4'd10:   ratio[g] = DIV_W'(36000);
        4'd11:   ratio[g] = DIV_W'(48000);
        4'd12:   ratio[g] = DIV_W'(72000);
        4'd15:   ratio[g] = DIV_W'(1);
        default: ratio[g] = '0;
      endcase
    end

    assign valid[g] = ratio[g] != '0;
    assign run[g]   = en[g] && gate[g] && valid[g] && !byp[g] && (!mode[g] || busy[g]);
    assign tick[g]  = gate[g] && valid[g] && pre[g] == ratio[g] - DIV_W'(1);
    assign wrap[g]  = run[g] && tick[g] && cnt[g] == cur[g][31:16];
    assign xfer[g]  = pend[g] && (!run[g] || wrap[g]);
    assign q[g]     = run[g] ? ((cnt[g] < cur[g][15:0]) ? act[g] : !act[g]) : !act[g];
    assign pwm_out[g] = byp[g] ? clk : q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code[g] <= '0; en[g] <= 1'b0; act[g] <= 1'b0; gate[g] <= 1'b0;
        mode[g] <= 1'b0; byp[g] <= 1'b0; busy[g] <= 1'b0; pend[g] <= 1'b0;
        shd[g] <= '0; cur[g] <= '0; cnt[g] <= '0; pre[g] <= '0;
      end else begin
        if (ctrl_we) begin
          en[g]   <= reg_wdata[B+4];
          act[g]  <= reg_wdata[B+5];
          gate[g] <= reg_wdata[B+6];
          mode[g] <= reg_wdata[B+7];
          byp[g]  <= reg_wdata[B+9];
          if (!gate[g]) code[g] <= reg_wdata[B+3:B];
        end

        if (!gate[g] || !valid[g] || tick[g] || start) pre[g] <= '0;
        else pre[g] <= pre[g] + DIV_W'(1);

        if (!run[g] || start) cnt[g] <= '0;
        else if (tick[g]) cnt[g] <= wrap[g] ? '0 : cnt[g] + CNT_W'(1);

        if (start) busy[g] <= 1'b1;
        else if (wrap[g] || !mode[g]) busy[g] <= 1'b0;

        if (pd_we) shd[g] <= reg_wdata;
        if (xfer[g]) cur[g] <= shd[g];
        if (pd_we) pend[g] <= 1'b1;
        else if (xfer[g]) pend[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 4'h0) begin
      for (int i = 0; i < NCH; i++) begin
        reg_rdata[i*STRIDE +: 10] = {byp[i], busy[i], mode[i], gate[i], act[i], en[i], code[i]};
        reg_rdata[RDY_LO + i] = pend[i];
      end
    end else begin
      for (int i = 0; i < NCH; i++)
        if (reg_addr == 4'(4 + 4 * i)) reg_rdata = shd[i];
    end
  end
endmodule

// File: rtl/pwm_ctl_chk.sv
module pwm_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        pend0,
  input logic        run0,
  input logic [15:0] cnt0,
  input logic [15:0] prd0,
  input logic [3:0]  code0,
  input logic        gate0,
  input logic        busy0,
  input logic        act0,
  input logic        q0
);
  a_r9_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h4) |=> pend0);

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run0 |-> cnt0 <= prd0);

  a_r7_idle_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run0 |=> cnt0 == 16'd0);

  a_r6_idle_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && $past(!run0) && $stable(act0)) |-> $stable(q0));

  a_r10_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gate0) |-> code0 == $past(code0));

  a_r11_pulse_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy0) |-> cnt0 == 16'd0);
endmodule

bind pwm_ctl pwm_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pend0(pend[0]), .run0(run[0]), .cnt0(cnt[0]), .prd0(cur[0][31:16]),
  .code0(code[0]), .gate0(gate[0]), .busy0(busy[0]), .act0(act[0]), .q0(q[0])
);

// File: tb/pwm_ctl_tb.sv
`timescale 1ns/1ps
module pwm_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_ctl u_dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .pwm_out);

  function automatic logic [31:0] cw(int ch, logic [3:0] c, logic e, logic a, logic g,
                                     logic m, logic p, logic b);
    logic [9:0] f = {b, p, m, g, a, e, c};
    return 32'(f) << (15 * ch);
  endfunction

  task automatic chk(string req, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic highs(int ch, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      #1; if (pwm_out[ch]) h++;
      @(negedge clk);
    end
  endtask

  task automatic idle_all();
    wr(4'h0, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl reset", d, 0);
    rd(4'h4, d); chk("R1 pd0 reset", d, 0);
    rd(4'h8, d); chk("R1 pd1 reset", d, 0);
    chk("R1 outputs idle high", pwm_out, 3);
  endtask

  task automatic t_basic_and_polarity();
    int h;
    wr(4'h4, (32'd9 << 16) | 32'd3);
    wr(4'h0, cw(0, 4'd15, 1, 1, 1, 0, 0, 0));
    highs(0, 50, h); chk("R2 duty 3 of 10", h, 15);
    idle_all();
    wr(4'h0, cw(0, 4'd15, 1, 0, 1, 0, 0, 0));
    highs(0, 50, h); chk("R3 inverted duty", h, 35);
    idle_all();
  endtask

  task automatic t_duty_edges();
    int h;
    wr(4'h4, (32'd9 << 16) | 32'd3);
    wr(4'h0, cw(0, 4'd15, 1, 1, 1, 0, 0, 0));
    wr(4'h4, (32'd9 << 16));
    repeat (15) @(negedge clk);
    highs(0, 50, h); chk("R4 duty zero", h, 0);
    wr(4'h4, (32'd9 << 16) | 32'd10);
    repeat (15) @(negedge clk);
    highs(0, 50, h); chk("R4 duty equals period", h, 50);
    wr(4'h4, (32'd9 << 16) | 32'd200);
    repeat (15) @(negedge clk);
    highs(0, 50, h); chk("R4 duty beyond period", h, 50);
    idle_all();
  endtask

  task automatic t_pending();
    logic [31:0] d;
    int h;
    wr(4'h4, (32'd99 << 16) | 32'd50);
    @(negedge clk);
    rd(4'h0, d); chk("R9 idle transfer clears ready", d[28], 0);
    wr(4'h0, cw(0, 4'd15, 1, 1, 1, 0, 0, 0));
    repeat (30) @(negedge clk);
    wr(4'h4, (32'd99 << 16) | 32'd10);
    rd(4'h0, d); chk("R9 ready set while period runs", d[28], 1);
    rd(4'h4, d); chk("R9 shadow readback", d, (32'd99 << 16) | 32'd10);
    repeat (105) @(negedge clk);
    rd(4'h0, d); chk("R9 ready cleared at boundary", d[28], 0);
    highs(0, 200, h); chk("R9 new duty in force", h, 20);
    idle_all();
  endtask

  task automatic t_enable_gate();
    int h;
    wr(4'h4, (32'd9 << 16) | 32'd5);
    wr(4'h0, cw(0, 4'd15, 1, 1, 0, 0, 0, 0));
    highs(0, 40, h); chk("R7 gate off holds inactive", h, 0);
    idle_all();
    wr(4'h0, cw(0, 4'd15, 0, 1, 1, 0, 0, 0));
    highs(0, 40, h); chk("R7 enable off holds inactive", h, 0);
    idle_all();
  endtask

  task automatic t_invalid_codes();
    int h;
    wr(4'h4, (32'd1 << 16) | 32'd1);
    wr(4'h0, cw(0, 4'd5, 1, 1, 1, 0, 0, 0));
    highs(0, 300, h); chk("R6 code 5 silent", h, 0);
    idle_all();
    wr(4'h0, cw(0, 4'd13, 1, 0, 1, 0, 0, 0));
    highs(0, 300, h); chk("R6 code 13 silent inverted", h, 300);
    idle_all();
  endtask

  task automatic t_prescale();
    int h;
    wr(4'h4, (32'd1 << 16) | 32'd1);
    wr(4'h0, cw(0, 4'd0, 1, 1, 1, 0, 0, 0));
    highs(0, 480, h); chk("R5 code 0 divides by 120", h, 240);
    idle_all();
    wr(4'h0, cw(0, 4'd4, 1, 1, 1, 0, 0, 0));
    highs(0, 960, h); chk("R5 code 4 divides by 480", h, 480);
    idle_all();
    wr(4'h0, cw(0, 4'd8, 1, 1, 1, 0, 0, 0));
    highs(0, 24000, h); chk("R5 code 8 divides by 12000", h, 12000);
    idle_all();
  endtask

  task automatic t_code_lock();
    logic [31:0] d;
    wr(4'h0, cw(0, 4'd15, 0, 0, 1, 0, 0, 0));
    wr(4'h0, cw(0, 4'd2, 0, 0, 1, 0, 0, 0));
    rd(4'h0, d); chk("R10 code held while gated on", d[3:0], 15);
    wr(4'h0, cw(0, 4'd2, 0, 0, 0, 0, 0, 0));
    wr(4'h0, cw(0, 4'd2, 0, 0, 1, 0, 0, 0));
    rd(4'h0, d); chk("R10 code taken while gated off", d[3:0], 2);
    idle_all();
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    int bad = 0;
    wr(4'h0, cw(0, 4'd6, 0, 1, 0, 0, 0, 1));
    rd(4'h0, d); chk("R8 bypass bit readback", d[9], 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1; if (pwm_out[0] !== 1'b0) bad++;
      @(posedge clk); #1; if (pwm_out[0] !== 1'b1) bad++;
    end
    chk("R8 output follows clock", bad, 0);
    idle_all();
  endtask

  task automatic t_one_shot();
    logic [31:0] d;
    int h;
    wr(4'h4, (32'd4 << 16) | 32'd2);
    wr(4'h0, cw(0, 4'd15, 1, 1, 1, 1, 0, 0));
    highs(0, 20, h); chk("R11 armed mode quiet", h, 0);
    wr(4'h0, cw(0, 4'd15, 1, 1, 1, 1, 1, 0));
    highs(0, 30, h); chk("R11 single period emitted", h, 2);
    rd(4'h0, d); chk("R11 pulse bit self-cleared", d[8], 0);
    idle_all();
  endtask

  task automatic t_channel1();
    logic [31:0] d;
    int h;
    wr(4'h8, (32'd3 << 16) | 32'd1);
    wr(4'h0, cw(1, 4'd15, 1, 1, 1, 0, 0, 0));
    rd(4'h0, d); chk("R12 ch1 enable at bit 19", d[19], 1);
    highs(1, 40, h); chk("R12 ch1 duty 1 of 4", h, 10);
    chk("R12 ch0 untouched", pwm_out[0], 1);
    wr(4'h8, (32'd3 << 16) | 32'd2);
    rd(4'h0, d); chk("R12 ch1 ready at bit 29", d[29], 1);
    chk("R12 ch0 ready untouched", d[28], 0);
    idle_all();
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_and_polarity();
    t_duty_edges();
    t_pending();
    t_enable_gate();
    t_invalid_codes();
    t_prescale();
    t_code_lock();
    t_bypass();
    t_one_shot();
    t_channel1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule